// File: doc/BRIEF.md
# Four-Decade Event Counter with Snapshot Latch and Scanned Display

This block counts events on a slow count input in four decimal digits, from 0000 up to 9999 and then back to 0000. A falling edge on the count input adds one. The count input, the latch control and the display selector are all sampled into a fast system clock domain through two-flop synchronisers. The counter itself runs in that domain. An active-high reset clears the counter at once, without waiting for a clock edge.

A snapshot register follows the live count while its control is high and freezes when the control goes low. The display can show either the live count or the frozen snapshot. The scanner drives one seven-segment digit at a time: a prescaler steps a digit index, and the segment lines are blanked for one system clock at every step so that no digit ghosts onto its neighbour.

A level carry output rises when the count reaches 6000 and falls when it returns to 0000. That falling edge can serve as the count input of a following stage.

Top module: `bcd4_scan_counter`

## Requirements
- R1: Each falling edge of `evt_clk` adds one to the four-digit BCD count, which wraps from 9999 to 0000. The new value is visible no more than four system clocks after the edge.
- R2: A rising edge of `evt_clk`, or a steady level on it, leaves the count unchanged.
- R3: While `rst` is high, the count is 0000 and `carry` is low, with no system clock edge needed. The snapshot is also 0000.
- R4: While `snap_n` is high, the snapshot follows the count. After `snap_n` falls, the snapshot keeps the value the count had at that moment, however far the count advances afterwards.
- R5: With `show_live` high, the display shows the live count. With `show_live` low, it shows the snapshot.
- R6: `carry` goes high when the count steps to 6000 and goes low when it steps to 0000. It does not change at any other step.
- R7: Exactly one bit of `dig_en` is high at any time. Bit k enables decimal digit k, where digit 0 is the least significant. The active bit moves from k to k+1 (and from 3 back to 0) once every `SCAN_DIV` system clocks.
- R8: `seg` bit 0 drives segment a and bit 6 drives segment g, all active high. The patterns for the digits 0 to 9, written as hex values of bits g..a, are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R9: In the system clock in which `dig_en` changes, `seg` is 0. In the next clock, it carries the pattern of the newly enabled digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the synchronisers, counter and scanner |
| rst | input | 1 | Asynchronous active-high reset |
| evt_clk | input | 1 | Event input; counts on its falling edge |
| snap_n | input | 1 | High: snapshot follows the count; low: snapshot holds |
| show_live | input | 1 | High: display the count; low: display the snapshot |
| seg | output | 7 | Segment lines a..g on bits 0..6, active high |
| dig_en | output | 4 | One-hot digit enable, bit 0 is the least significant digit |
| carry | output | 1 | High from 6000 until the count returns to 0000 |

## Verification
The bench walks the count through 5999→6000 and 9999→0000. A counter that carried at the wrong place, or a carry built as a single pulse, would show a wrong `carry` level at those points, and a missing BCD wrap would show hex digits. It freezes the snapshot and keeps counting. A snapshot that kept following the count, or a display that read from the wrong source, would show the live value where the frozen one belongs. It also drives lone rising edges on the count input: a design that counts on the wrong edge would then step once too often. The bench follows the scan across every digit change, so a skipped blanking cycle, a wrong rotation order or a wrong dwell time all show up.

// File: rtl/bcd4_scan_counter.sv
module bcd4_scan_counter #(
  parameter int SCAN_DIV = 125000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_clk,
  input  logic       snap_n,
  input  logic       show_live,
  output logic [6:0] seg,
  output logic [3:0] dig_en,
  output logic       carry
);
  localparam int DW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic [2:0]  evt_s;
  logic [1:0]  snap_s, live_s;
  logic [15:0] cnt, cnt_nxt, snap;
  logic [DW-1:0] pre;
  logic [1:0]  idx;
  logic        blank;
  logic        fall, tick;
  logic [15:0] shown;
  logic [3:0]  cur;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      evt_s  <= 3'b000;
      snap_s <= 2'b00;
      live_s <= 2'b00;
    end else begin
      evt_s  <= {evt_s[1:0], evt_clk};
      snap_s <= {snap_s[0], snap_n};
      live_s <= {live_s[0], show_live};
    end

  assign fall = evt_s[2] & ~evt_s[1];

  always_comb begin
    logic c;
    cnt_nxt = cnt;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c) begin
        if (cnt[4*i +: 4] == 4'd9) cnt_nxt[4*i +: 4] = 4'd0;
        else begin
          cnt_nxt[4*i +: 4] = cnt[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      cnt   <= '0;
      carry <= 1'b0;
    end else if (fall) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == 16'h6000) carry <= 1'b1;
      else if (cnt_nxt == 16'h0000) carry <= 1'b0;
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) snap <= '0;
    else if (snap_s[1]) snap <= cnt;

  assign tick = (pre == DW'(SCAN_DIV - 1));

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      pre   <= '0;
      idx   <= 2'd0;
      blank <= 1'b0;
    end else begin
      pre   <= tick ? '0 : pre + 1'b1;
      idx   <= idx + {1'b0, tick};
      blank <= tick;
    end

  assign shown  = live_s[1] ? cnt : snap;
  assign cur    = shown[4*idx +: 4];
  assign dig_en = 4'b0001 << idx;

  always_comb begin
    logic [6:0] p;
    case (cur)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    seg = blank ? 7'h00 : p;
  end

  AST_NO_STEP_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst) !fall |=> $stable(cnt)); // R2
  AST_CARRY_AT_6000: assert property (@(posedge clk) disable iff (rst) (cnt == 16'h6000) |-> carry); // R6
  AST_CARRY_AT_0000: assert property (@(posedge clk) disable iff (rst) (cnt == 16'h0000) |-> !carry); // R6
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst) !snap_s[1] |=> $stable(snap)); // R4
  AST_DIG_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot(dig_en)); // R7
  AST_BLANK_ON_STEP: assert property (@(posedge clk) disable iff (rst) !$stable(dig_en) |-> (seg == 7'h00)); // R9
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst) (cnt[3:0] < 4'd10) && (cnt[7:4] < 4'd10) && (cnt[11:8] < 4'd10) && (cnt[15:12] < 4'd10)); // R1
endmodule

// File: tb/bcd4_scan_counter_bench.sv
module bcd4_scan_counter_bench;
  localparam int DIV = 4;
  logic clk = 1'b0, rst = 1'b1, evt_clk = 1'b1, snap_n = 1'b1, show_live = 1'b1;
  logic [6:0] seg;
  logic [3:0] dig_en;
  logic carry;
  int checks = 0, fails = 0;
  int m_cnt = 0, m_snap = 0;
  bit m_carry = 0, m_frozen = 0;

  always #4 clk = ~clk;

  bcd4_scan_counter #(.SCAN_DIV(DIV)) u_bcd4_scan_counter (
    .clk(clk), .rst(rst), .evt_clk(evt_clk), .snap_n(snap_n),
    .show_live(show_live), .seg(seg), .dig_en(dig_en), .carry(carry));

  function automatic logic [6:0] pat(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic int unpat(logic [6:0] s);
    for (int d = 0; d < 10; d++) if (pat(d) == s) return d;
    return 99;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    evt_clk = 1'b0;
    repeat (4) @(negedge clk);
    evt_clk = 1'b1;
    repeat (4) @(negedge clk);
    m_cnt = (m_cnt + 1) % 10000;
    if (m_cnt == 6000) m_carry = 1;
    if (m_cnt == 0) m_carry = 0;
    if (!m_frozen) m_snap = m_cnt;
  endtask

  task automatic set_snap(bit v);
    snap_n = v;
    m_frozen = !v;
    if (v) m_snap = m_cnt;
    repeat (5) @(negedge clk);
  endtask

  task automatic read_disp(output int val);
    int dg[4];
    for (int k = 0; k < 4; k++) dg[k] = 99;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 4 * DIV + 4; c++) begin
      @(negedge clk);
      if (seg != 7'h00)
        for (int k = 0; k < 4; k++) if (dig_en[k]) dg[k] = unpat(seg);
    end
    val = dg[0] + 10 * dg[1] + 100 * dg[2] + 1000 * dg[3];
  endtask

  task automatic scan_check();
    logic [3:0] prev;
    int run = -1;
    @(negedge clk);
    prev = dig_en;
    for (int c = 0; c < 6 * DIV; c++) begin
      @(negedge clk);
      check("R7 one-hot", $countones(dig_en), 1);
      if (dig_en != prev) begin
        check("R7 order", dig_en, {prev[2:0], prev[3]});
        check("R9 blank", seg, 0);
        if (run >= 0) check("R7 dwell", run, DIV);
        run = 1;
        prev = dig_en;
        @(negedge clk);
        check("R9 unblank", (seg != 7'h00) ? 1 : 0, 1);
        run++;
      end else if (run >= 0) run++;
    end
  endtask

  initial begin
    int v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    read_disp(v); check("R3 reset count", v, 0);
    check("R3 reset carry", carry, 0);
    scan_check();

    for (int i = 0; i < 3; i++) pulse();
    read_disp(v); check("R1 count 3", v, 3);

    evt_clk = 1'b0; repeat (2) @(negedge clk);
    rst = 1'b1; #1;
    check("R3 async carry", carry, 0);
    evt_clk = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0; m_cnt = 0; m_snap = 0; m_carry = 0;
    repeat (4) @(negedge clk);
    read_disp(v); check("R3 async count", v, 0);

    evt_clk = 1'b0; repeat (6) @(negedge clk);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);
    evt_clk = 1'b1; repeat (8) @(negedge clk);
    read_disp(v); check("R2 rising edge ignored", v, 0);

    for (int r = 0; r < 12; r++) begin
      int n = 1 + ($urandom % 30);
      for (int i = 0; i < n; i++) pulse();
      if (($urandom % 3) == 0) set_snap(!snap_n);
      show_live = $urandom % 2;
      read_disp(v);
      check(show_live ? "R5 live" : "R5 snap", v, show_live ? m_cnt : m_snap);
      check("R8 decode", v, show_live ? m_cnt : m_snap);
    end
    set_snap(1);

    set_snap(0);
    v = m_cnt;
    for (int i = 0; i < 7; i++) pulse();
    show_live = 1'b0; read_disp(v);
    check("R4 snapshot held", v, m_snap);
    show_live = 1'b1; read_disp(v);
    check("R5 live while held", v, m_cnt);
    set_snap(1);
    show_live = 1'b0; read_disp(v);
    check("R4 snapshot follows", v, m_cnt);
    show_live = 1'b1;

    while (m_cnt != 5999) begin
      pulse();
      if (m_cnt == 5000) check("R6 carry low below 6000", carry, 0);
    end
    check("R6 carry at 5999", carry, 0);
    pulse();
    check("R6 carry at 6000", carry, 1);
    read_disp(v); check("R1 count 6000", v, 6000);
    while (m_cnt != 9999) pulse();
    check("R6 carry at 9999", carry, 1);
    read_disp(v); check("R1 count 9999", v, 9999);
    pulse();
    check("R6 carry after wrap", carry, 0);
    read_disp(v); check("R1 wrap to 0000", v, 0);
    pulse();
    read_disp(v); check("R1 after wrap", v, 1);
    check("R6 carry stays low", carry, m_carry);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule